// File: doc/BRIEF.md
# Direct-Sequence Chip Spreader

The block turns a slow serial data stream into a fast chip stream for a direct-sequence spread-spectrum transmitter. A maximal-length pseudo-noise code comes from a Fibonacci linear feedback shift register. Each data bit is held for a set number of chips, and every output chip is that bit XORed with the code chip of the moment. Chips advance only on a chip-rate enable, so the bit rate is the chip rate divided by the chips-per-bit count. The code phase runs on without a break across bit boundaries and across gaps in the data.

Data enters on a valid/ready handshake with the following back-pressure rules. `in_ready` is high only during a chip tick that opens a new bit. A bit transfers on a cycle where `in_valid` and `in_ready` are both high. Once the source raises `in_valid`, it keeps `in_valid` and `in_data` steady until the transfer happens. If no valid bit is waiting when a bit opens, the block does not stall. It spreads a zero bit for that whole bit period. The chips-per-bit input is plain control and is sampled only when a bit opens.

The outputs are registered and appear one clock after the tick that produced them. A period-start strobe marks the first chip of each code period.

Top module: `dsss_chip_spreader`

## Requirements
- R1: While `rst` is high, and after it until the first chip tick, `chip_valid`, `chip_out` and `period_start` are 0. The code restarts at its seed and the bit framing restarts at the start of a bit.
- R2: `chip_valid` is high in the clock cycle after each cycle where `chip_tick` is high, and low otherwise. `chip_out` and `period_start` belong to that tick.
- R3: Write the code as a[k], with k counting chip ticks from reset. The first ten code chips are the seed bits, bit 0 first (default seed 10'h001, giving 1 followed by nine 0s). After that, a[k+10] = a[k] XOR a[k+3]. This is the recurrence of x^10+x^7+1.
- R4: The code repeats every 1023 chips. `period_start` is high exactly with chips whose index k is a multiple of 1023. Each period holds 512 ones.
- R5: Each chip equals the current data bit XOR the current code chip.
- R6: A bit lasts exactly N chips, where N is `chips_per_bit` sampled at the tick that opens the bit. A value of 0 acts as 1. A change in the middle of a bit takes effect at the next bit.
- R7: `in_ready` is high only in a cycle with `chip_tick` high that opens a bit. A bit transfers when `in_valid` and `in_ready` are both high.
- R8: If `in_valid` is low when a bit opens, that whole bit is spread as 0 and no transfer occurs.
- R9: The register state is never all-zero, so the code never holds more than nine consecutive zero chips. If an all-zero state were ever seen, the seed would be reloaded.
- R10: The code phase advances on every tick, whatever the bit boundaries, data gaps or chips-per-bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chip_tick | input | 1 | Chip-rate enable, one chip per high cycle |
| chips_per_bit | input | 8 | Chips per data bit, 0 treated as 1 |
| in_valid | input | 1 | Data bit offered |
| in_data | input | 1 | Data bit value |
| in_ready | output | 1 | Bit accepted this cycle when valid is also high |
| chip_out | output | 1 | Spread chip |
| chip_valid | output | 1 | Strobe for `chip_out` |
| period_start | output | 1 | First chip of a code period |

## Verification
An all-zero, never-valid run of more than two periods exposes the bare code. That run checks the seed prefix, the recurrence, the 1023-chip period, the count of ones and the longest zero run. Alternating and pseudo-random data at one, three, thirteen and 255 chips per bit separate a correct XOR from framing-length errors. Irregular tick patterns combined with sparse valid show that ready follows ticks and bit openings rather than clock cycles, and that the code never pauses during data gaps. A length change in the middle of a bit and a zero length exercise the rule that samples the length when a bit opens and the rule that treats 0 as 1.

// File: rtl/spread_pkg.sv
package spread_pkg;
  localparam int unsigned CODE_W_DEF = 10;
  localparam int unsigned LEN_W_DEF  = 8;

  typedef struct packed {
    logic chip;
    logic valid;
    logic pstart;
  } chip_beat_t;
endpackage

// File: rtl/spread_pn_lfsr.sv
module spread_pn_lfsr #(
  parameter int unsigned W        = 10,
  parameter logic [W-1:0] TAP_MASK = 10'h009,
  parameter logic [W-1:0] SEED     = 10'h001
) (
  input  logic clk,
  input  logic rst,
  input  logic advance,
  output logic code_chip,
  output logic at_seed
);
  logic [W-1:0] state;
  logic         fb;

  assign fb        = ^(state & TAP_MASK);
  assign code_chip = state[0];
  assign at_seed   = (state == SEED);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEED;
    end else if (state == '0) begin
      state <= SEED;
    end else if (advance) begin
      state <= {fb, state[W-1:1]};
    end
  end

  p_state_nonzero_r9: assert property (@(posedge clk) disable iff (rst)
    state != '0);
  p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(state));
endmodule

// File: rtl/spread_bit_framer.sv
module spread_bit_framer #(
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [LEN_W-1:0] len_cfg,
  input  logic             in_valid,
  input  logic             in_data,
  output logic             in_ready,
  output logic             bit_val
);
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] cur_len;
  logic [LEN_W-1:0] eff_len;
  logic [LEN_W-1:0] use_len;
  logic             held;
  logic             opening;

  assign opening  = (cnt == '0);
  assign eff_len  = (len_cfg == '0) ? LEN_W'(1) : len_cfg;
  assign use_len  = opening ? eff_len : cur_len;
  assign in_ready = tick & opening;
  assign bit_val  = opening ? (in_valid & in_data) : held;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      cur_len <= LEN_W'(1);
      held    <= 1'b0;
    end else if (tick) begin
      cnt <= (cnt == use_len - LEN_W'(1)) ? '0 : cnt + LEN_W'(1);
      if (opening) begin
        cur_len <= eff_len;
        held    <= in_valid & in_data;
      end
    end
  end

  p_ready_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> tick);
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
    !opening |-> (cnt < cur_len));
  p_len_stable_r6: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> $stable(cur_len));
endmodule

// File: rtl/spread_chip_out.sv
module spread_chip_out
  import spread_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       bit_val,
  input  logic       code_chip,
  input  logic       at_seed,
  output chip_beat_t beat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      beat <= '0;
    end else begin
      beat.valid  <= tick;
      beat.chip   <= tick & (bit_val ^ code_chip);
      beat.pstart <= tick & at_seed;
    end
  end

  p_vld_after_tick_r2: assert property (@(posedge clk) disable iff (rst)
    tick |=> beat.valid);
  p_no_vld_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> !beat.valid);
endmodule

// File: rtl/dsss_chip_spreader.sv
module dsss_chip_spreader
  import spread_pkg::*;
#(
  parameter int unsigned CODE_W = CODE_W_DEF,
  parameter logic [CODE_W-1:0] TAP_MASK = 10'h009,
  parameter logic [CODE_W-1:0] SEED = 10'h001,
  parameter int unsigned LEN_W = LEN_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chip_tick,
  input  logic [LEN_W-1:0] chips_per_bit,
  input  logic             in_valid,
  input  logic             in_data,
  output logic             in_ready,
  output logic             chip_out,
  output logic             chip_valid,
  output logic             period_start
);
  logic       code_chip;
  logic       at_seed;
  logic       bit_val;
  chip_beat_t beat;

  spread_pn_lfsr #(.W(CODE_W), .TAP_MASK(TAP_MASK), .SEED(SEED)) u_pn (
    .clk(clk), .rst(rst), .advance(chip_tick),
    .code_chip(code_chip), .at_seed(at_seed)
  );

  spread_bit_framer #(.LEN_W(LEN_W)) u_framer (
    .clk(clk), .rst(rst), .tick(chip_tick), .len_cfg(chips_per_bit),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .bit_val(bit_val)
  );

  spread_chip_out u_out (
    .clk(clk), .rst(rst), .tick(chip_tick), .bit_val(bit_val),
    .code_chip(code_chip), .at_seed(at_seed), .beat(beat)
  );

  assign chip_out     = beat.chip;
  assign chip_valid   = beat.valid;
  assign period_start = beat.pstart;

  p_pstart_with_vld_r4: assert property (@(posedge clk) disable iff (rst)
    period_start |-> chip_valid);
endmodule

// File: tb/dsss_chip_spreader_test.sv
module dsss_chip_spreader_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       chip_tick = 1'b0;
  logic [7:0] chips_per_bit = 8'd8;
  logic       in_valid = 1'b0;
  logic       in_data = 1'b0;
  logic       in_ready, chip_out, chip_valid, period_start;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench model
  logic [9:0] ms = 10'h001;
  int mcnt = 0, mlen = 1, midx = 0, cyc = 0;
  bit mbit = 0;
  bit src_valid = 0, src_data = 0;
  int data_ctr = 0;
  bit hold_off = 1;
  bit gap_mode = 0;
  int zrun = 0, zmax = 0, ones = 0;

  dsss_chip_spreader uut (
    .clk(clk), .rst(rst), .chip_tick(chip_tick), .chips_per_bit(chips_per_bit),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .chip_out(chip_out), .chip_valid(chip_valid), .period_start(period_start)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (chip %0d)", req, act, exp, midx);
    end
  endtask

  task automatic step(input bit t);
    bit accepted, exp_rdy, ec, ep, code;
    int eff;
    accepted = 0; ec = 0; ep = 0; code = 0;
    @(negedge clk);
    cyc++;
    if (!src_valid && !hold_off)
      src_valid = gap_mode ? (cyc % 5 == 2) : 1'b1;
    chip_tick = t;
    in_valid  = src_valid;
    in_data   = src_data;
    #1;
    exp_rdy = t && (mcnt == 0);
    chk(in_ready == exp_rdy, "R6 R7 ready", in_ready, exp_rdy);
    if (t) begin
      if (mcnt == 0) begin
        eff = (chips_per_bit == 0) ? 1 : int'(chips_per_bit);
        mlen = eff;
        mbit = src_valid & src_data;   // R8: absent data spreads as 0
        accepted = src_valid;
      end
      code = ms[0];
      ec = mbit ^ code;
      ep = (midx % 1023 == 0);
      mcnt = (mcnt == mlen - 1) ? 0 : mcnt + 1;
      ms = {ms[0] ^ ms[3], ms[9:1]};   // a[k+10] = a[k] ^ a[k+3]
      if (hold_off) begin
        if (code) begin zrun = 0; if (midx < 1023) ones++; end
        else begin zrun++; if (zrun > zmax) zmax = zrun; end
      end
    end
    @(posedge clk);
    #1;
    chk(chip_valid == t, "R2 chip_valid", chip_valid, t);
    if (t) begin
      if (midx < 10 && hold_off)
        chk(chip_out == ((10'h001 >> midx) & 1), "R3 seed prefix", chip_out, (10'h001 >> midx) & 1);
      chk(chip_out == ec, "R5 R10 chip", chip_out, ec);
      chk(period_start == ep, "R4 period_start", period_start, ep);
      midx++;
    end else begin
      chk(period_start == 0, "R2 idle period_start", period_start, 0);
    end
    if (accepted) begin
      src_valid = 0;
      data_ctr++;
      src_data = data_ctr[0] ^ data_ctr[2] ^ (data_ctr % 7 == 3);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(chip_valid == 0, "R1 reset valid", chip_valid, 0);
    chk(chip_out == 0, "R1 reset chip", chip_out, 0);
    chk(period_start == 0, "R1 reset pstart", period_start, 0);
    @(negedge clk);
    rst = 1'b0;
    step(1'b0);
    chk(chip_valid == 0, "R1 idle after reset", chip_valid, 0);

    // bare code: no valid data, 8 chips per bit
    hold_off = 1;
    for (int i = 0; i < 2200; i++) step(1'b1);
    chk(zmax == 9, "R9 longest zero run", zmax, 9);
    chk(ones == 512, "R4 ones per period", ones, 512);

    // alternating-ish data, one chip per bit
    hold_off = 0; gap_mode = 0;
    chips_per_bit = 8'd1;
    for (int i = 0; i < 300; i++) step(1'b1);

    // irregular ticks, sparse valid, three chips per bit (R8, R10)
    chips_per_bit = 8'd3; gap_mode = 1;
    for (int i = 0; i < 600; i++) step((i % 3) != 1);

    // long bits and a mid-bit length change (R6)
    gap_mode = 0; chips_per_bit = 8'd13;
    for (int i = 0; i < 20; i++) step(1'b1);
    chips_per_bit = 8'd5;
    for (int i = 0; i < 60; i++) step(1'b1);

    // zero length acts as one (R6)
    chips_per_bit = 8'd0;
    for (int i = 0; i < 40; i++) step((i % 4) != 0);

    // maximum length
    chips_per_bit = 8'd255;
    for (int i = 0; i < 800; i++) step(1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule